// File: doc/BRIEF.md
# Read-Pattern Command Detector

This block watches the access stream of a byte-wide memory and recognises a fixed, ordered pattern of six read addresses as a command. The first five addresses form a common prefix. The sixth address chooses between a store request and a recall request. Each request is issued to the store/recall controller as a one-cycle pulse.

Each access arrives as an access strobe together with a read/write flag and a 15-bit address. A strobe that stays high for several cycles is one access. Any access that does not continue the pattern abandons the attempt. While the controller reports busy, the detector ignores accesses and starts over.

The access stream has no valid/ready pair. The detector accepts every access in the cycle the strobe rises and never applies back-pressure. All pins are plain control and status signals.

Top module: `swcmd_detect`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `store_pulse` and `recall_pulse` are both low. Reset puts the detector back at the start, waiting for the first pattern address.
- R2: The pattern is a read at 0x0E38, then 0x31C7, 0x03E0, 0x3C1F and 0x303F, then a sixth read at 0x0FC0. Reads in exactly that order raise `store_pulse` for exactly one cycle. The pulse appears in the cycle after the clock edge that samples the sixth access's strobe rise.
- R3: The same five-read prefix followed by a read at 0x0C63 raises `recall_pulse` for exactly one cycle, with the same timing as R2.
- R4: An access with `acc_is_read` = 0 (a write) at any point in the pattern abandons the attempt. No command follows unless the whole pattern is read again.
- R5: A read at an address other than the next expected one abandons the attempt. No command is issued.
- R6: A read at 0x0E38 that does not continue the pattern counts as the first step of a new attempt. This also holds when it arrives in place of the sixth read.
- R7: An access counts once, on the clock edge where `acc_strobe` is high after being low. Further cycles with the strobe held high have no effect.
- R8: In any cycle where `nv_busy` is high, an access is ignored, the pattern progress is cleared and no pulse is produced on the next cycle.
- R9: `store_pulse` and `recall_pulse` are never high together, and neither is high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_strobe | input | 1 | High during one memory access; its rising edge marks the access |
| acc_is_read | input | 1 | 1 = read access, 0 = write access |
| acc_addr | input | 15 | Byte address of the access |
| nv_busy | input | 1 | Store/recall controller is busy |
| store_pulse | output | 1 | One-cycle store request |
| recall_pulse | output | 1 | One-cycle recall request |

## Verification
The assertions check every cycle that a write, a held strobe or an active busy never leads to a pulse on the next cycle. They also check that the two pulses are exclusive and one cycle wide. Whether a correct six-read pattern actually yields its command cannot be judged cycle by cycle. The same is true of an abort that only shows several accesses later, and of a 0x0E38 read restarting the attempt. The bench shows these by sweeping every abort position against every kind of disturbance and comparing each cycle with an expected model.

// File: rtl/swcmd_pkg.sv
package swcmd_pkg;
  localparam int ADDR_W     = 15;
  localparam int PREFIX_LEN = 5;

  localparam logic [ADDR_W-1:0] STORE_ADDR  = 15'h0FC0;
  localparam logic [ADDR_W-1:0] RECALL_ADDR = 15'h0C63;

  // Address expected at prefix position idx (0 = first read)
  function automatic logic [ADDR_W-1:0] prefix_addr(input int idx);
    case (idx)
      0:       return 15'h0E38;
      1:       return 15'h31C7;
      2:       return 15'h03E0;
      3:       return 15'h3C1F;
      default: return 15'h303F;
    endcase
  endfunction

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_STORE  = 2'd1,
    CMD_RECALL = 2'd2
  } cmd_e;
endpackage

// File: rtl/swcmd_edge.sv
module swcmd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/swcmd_match.sv
module swcmd_match #(
  parameter int ADDR_W     = swcmd_pkg::ADDR_W,
  parameter int PREFIX_LEN = swcmd_pkg::PREFIX_LEN,
  localparam int STEP_W    = $clog2(PREFIX_LEN + 1)
) (
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_next,
  output logic              hit_first,
  output logic              hit_store,
  output logic              hit_recall
);
  logic [PREFIX_LEN-1:0] pos_hit;

  for (genvar g = 0; g < PREFIX_LEN; g++) begin : g_cmp
    localparam logic [ADDR_W-1:0] EXP = swcmd_pkg::prefix_addr(g);
    assign pos_hit[g] = (addr == EXP) && (step == STEP_W'(g));
  end

  assign hit_next   = |pos_hit;
  assign hit_first  = (addr == swcmd_pkg::prefix_addr(0));
  assign hit_store  = (addr == swcmd_pkg::STORE_ADDR);
  assign hit_recall = (addr == swcmd_pkg::RECALL_ADDR);
endmodule

// File: rtl/swcmd_seq.sv
module swcmd_seq #(
  parameter int PREFIX_LEN = swcmd_pkg::PREFIX_LEN,
  localparam int STEP_W    = $clog2(PREFIX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic              is_read,
  input  logic              busy,
  input  logic              hit_next,
  input  logic              hit_first,
  input  logic              hit_store,
  input  logic              hit_recall,
  output logic [STEP_W-1:0] step,
  output logic              store_pulse,
  output logic              recall_pulse
);
  import swcmd_pkg::*;

  localparam logic [STEP_W-1:0] LAST = STEP_W'(PREFIX_LEN);

  logic [STEP_W-1:0] step_n;
  cmd_e              cmd_n, cmd_q;
  logic [STEP_W-1:0] restart;

  assign restart = hit_first ? STEP_W'(1) : '0;

  always_comb begin
    step_n = step;
    cmd_n  = CMD_NONE;
    if (busy) begin
      step_n = '0;
    end else if (evt) begin
      if (!is_read) begin
        step_n = '0;
      end else if (step == LAST) begin
        if (hit_store) begin
          cmd_n  = CMD_STORE;
          step_n = '0;
        end else if (hit_recall) begin
          cmd_n  = CMD_RECALL;
          step_n = '0;
        end else begin
          step_n = restart;
        end
      end else if (hit_next) begin
        step_n = step + STEP_W'(1);
      end else begin
        step_n = restart;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step  <= '0;
      cmd_q <= CMD_NONE;
    end else begin
      step  <= step_n;
      cmd_q <= cmd_n;
    end
  end

  assign store_pulse  = (cmd_q == CMD_STORE);
  assign recall_pulse = (cmd_q == CMD_RECALL);
endmodule

// File: rtl/swcmd_detect.sv
module swcmd_detect #(
  parameter int ADDR_W     = swcmd_pkg::ADDR_W,
  parameter int PREFIX_LEN = swcmd_pkg::PREFIX_LEN,
  localparam int STEP_W    = $clog2(PREFIX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_strobe,
  input  logic              acc_is_read,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              nv_busy,
  output logic              store_pulse,
  output logic              recall_pulse
);
  logic              evt;
  logic [STEP_W-1:0] step;
  logic              hit_next, hit_first, hit_store, hit_recall;

  swcmd_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (acc_strobe),
    .rise  (evt)
  );

  swcmd_match #(.ADDR_W(ADDR_W), .PREFIX_LEN(PREFIX_LEN)) u_match (
    .step       (step),
    .addr       (acc_addr),
    .hit_next   (hit_next),
    .hit_first  (hit_first),
    .hit_store  (hit_store),
    .hit_recall (hit_recall)
  );

  swcmd_seq #(.PREFIX_LEN(PREFIX_LEN)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt          (evt),
    .is_read      (acc_is_read),
    .busy         (nv_busy),
    .hit_next     (hit_next),
    .hit_first    (hit_first),
    .hit_store    (hit_store),
    .hit_recall   (hit_recall),
    .step         (step),
    .store_pulse  (store_pulse),
    .recall_pulse (recall_pulse)
  );
endmodule

// File: rtl/swcmd_detect_chk.sv
module swcmd_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic acc_strobe,
  input logic acc_is_read,
  input logic nv_busy,
  input logic store_pulse,
  input logic recall_pulse
);
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_pulse && recall_pulse)); // R9

  AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    store_pulse |=> !store_pulse); // R9

  AST_RECALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    recall_pulse |=> !recall_pulse); // R9

  AST_BUSY_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |=> !(store_pulse || recall_pulse)); // R8

  AST_WRITE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_strobe && !acc_is_read) |=> !(store_pulse || recall_pulse)); // R4

  AST_HELD_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_strobe && $past(acc_strobe)) |=> !(store_pulse || recall_pulse)); // R7
endmodule

bind swcmd_detect swcmd_detect_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_strobe   (acc_strobe),
  .acc_is_read  (acc_is_read),
  .nv_busy      (nv_busy),
  .store_pulse  (store_pulse),
  .recall_pulse (recall_pulse)
);

// File: tb/swcmd_detect_tb_top.sv
`timescale 1ns/1ps
module swcmd_detect_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_strobe = 1'b0;
  logic        acc_is_read = 1'b1;
  logic [14:0] acc_addr = '0;
  logic        nv_busy = 1'b0;
  logic        store_pulse, recall_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_step = 0;
  logic [14:0] pat [0:6];

  always #4 clk = ~clk;

  swcmd_detect dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_strobe   (acc_strobe),
    .acc_is_read  (acc_is_read),
    .acc_addr     (acc_addr),
    .nv_busy      (nv_busy),
    .store_pulse  (store_pulse),
    .recall_pulse (recall_pulse)
  );

  task automatic chk(input string tag, input logic es, input logic er);
    checks++;
    if (store_pulse !== es || recall_pulse !== er) begin
      errors++;
      $display("FAIL %s: store/recall got %b/%b expected %b/%b at %0t",
               tag, store_pulse, recall_pulse, es, er, $time);
    end
  endtask

  // Expected behaviour from the requirements: returns 1 store, 2 recall, 0 none
  function automatic int model(input bit rd, input logic [14:0] a, input bit bsy);
    int cmd = 0;
    if (bsy) m_step = 0;
    else if (!rd) m_step = 0;
    else if (m_step == 5) begin
      if (a == 15'h0FC0) begin cmd = 1; m_step = 0; end
      else if (a == 15'h0C63) begin cmd = 2; m_step = 0; end
      else m_step = (a == 15'h0E38) ? 1 : 0;
    end else if (a == pat[m_step]) m_step++;
    else m_step = (a == 15'h0E38) ? 1 : 0;
    return cmd;
  endfunction

  task automatic access(input string tag, input bit rd, input logic [14:0] a,
                        input int hold, input bit bsy);
    int cmd;
    @(negedge clk);
    acc_strobe = 1'b1; acc_is_read = rd; acc_addr = a; nv_busy = bsy;
    cmd = model(rd, a, bsy);
    @(posedge clk); #1;
    chk(tag, cmd == 1, cmd == 2);
    for (int h = 0; h < hold; h++) begin
      @(posedge clk); #1;
      chk("R7", 1'b0, 1'b0);
    end
    @(negedge clk);
    acc_strobe = 1'b0; nv_busy = 1'b0;
    @(posedge clk); #1;
    chk(tag, 1'b0, 1'b0);
  endtask

  task automatic full_cmd(input string tag, input logic [14:0] last, input int hold);
    for (int i = 0; i < 5; i++) access(tag, 1'b1, pat[i], hold, 1'b0);
    access(tag, 1'b1, last, hold, 1'b0);
  endtask

  initial begin
    pat[0] = 15'h0E38; pat[1] = 15'h31C7; pat[2] = 15'h03E0;
    pat[3] = 15'h3C1F; pat[4] = 15'h303F; pat[5] = 15'h0FC0; pat[6] = 15'h0C63;
    repeat (3) @(posedge clk);
    #1 chk("R1", 1'b0, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 chk("R1", 1'b0, 1'b0);

    // Full commands, with and without a held strobe
    for (int h = 0; h < 3; h++) begin
      full_cmd("R2", pat[5], h);
      full_cmd("R3", pat[6], h);
    end

    // Disturbance at every position: 0 write, 1 wrong read, 2 busy read
    for (int pos = 0; pos < 6; pos++) begin
      for (int kind = 0; kind < 3; kind++) begin
        for (int last = 5; last < 7; last++) begin
          for (int i = 0; i < pos; i++) access("R2", 1'b1, pat[i], 0, 1'b0);
          case (kind)
            0: access("R4", 1'b0, pat[pos], 0, 1'b0);
            1: access("R5", 1'b1, pat[pos] ^ 15'h0101, 0, 1'b0);
            default: access("R8", 1'b1, pat[pos], 0, 1'b1);
          endcase
          for (int i = pos; i < 6; i++)
            access(last == 5 ? "R2" : "R3", 1'b1, (i == 5) ? pat[last] : pat[i], 0, 1'b0);
          full_cmd(last == 5 ? "R2" : "R3", pat[last], 0);
        end
      end
    end

    // Restart on 0x0E38 at every position, including the sixth
    for (int pos = 1; pos < 6; pos++) begin
      for (int i = 0; i < pos; i++) access("R6", 1'b1, pat[i], 0, 1'b0);
      access("R6", 1'b1, 15'h0E38, 0, 1'b0);
      for (int i = 1; i < 6; i++) access("R6", 1'b1, pat[i], 0, 1'b0);
    end

    // Busy held while the strobe rises: full pattern ignored
    for (int i = 0; i < 6; i++) access("R8", 1'b1, pat[i], 1, 1'b1);

    // Mid-sequence reset
    for (int i = 0; i < 5; i++) access("R1", 1'b1, pat[i], 0, 1'b0);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    m_step = 0;
    access("R1", 1'b1, pat[5], 0, 1'b0);
    full_cmd("R2", pat[5], 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule